// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a four-input, 8-bit successive-approximation analog-to-digital converter. Software sees it as two byte-wide registers on a simple write/read bus:

- a control/status register at 0xEC;
- a read-only result register at 0xED.

A conversion starts when software writes the control register with both the enable bit and the start bit set. The block first latches the chosen input channel and drives it onto the analog multiplexer select. It then holds the sample-and-hold strobe for a fixed number of sample cycles. After that it runs a binary search on the external DAC ladder, one bit per cycle, from the most significant bit down to the least significant bit. Each step reads a single comparator bit.

When the last bit is resolved, three things happen on the same clock edge:

- the code is loaded into the result register;
- the interrupt flag rises;
- the status bit returns to "complete".

The interrupt flag stays up until it is cleared with a separate strobe. The ladder, the comparator and the sample-and-hold circuit are outside this block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the control register reads 0x01 (enable 0, channel 0, start 0, status 1). The result register reads 0x00, the interrupt flag is 0 and the sample strobe is 0.
- R2: Control register layout:
  - bit 6 is the enable;
  - bits 3:2 are the channel;
  - bit 1 is the start bit;
  - bit 0 is the read-only status bit;
  - bits 7, 5 and 4 always read 0.
  
  For example, writing 0xFD reads back 0x4D.
- R3: The channel encoding 00/01/10/11 selects input 0/1/2/3. The mux select carries the channel that was captured at the start and stays fixed while a conversion runs, even if the control register is rewritten during that conversion.
- R4: The start bit reads 1 in the cycle after an accepted start write. It reads 0 from the cycle after that onwards. Writing 0 to the start bit has no effect.
- R5: A start write whose enable bit (bit 6) is 0 is ignored. The status bit stays 1 and no sampling begins.
- R6: A start write that arrives while a conversion is running is ignored. The running conversion finishes at its original time, with its original channel and result.
- R7: The status bit reads 0 from the cycle after an accepted start until the result is loaded, and reads 1 from then on.
- R8: After an accepted start, the sample strobe is high for exactly SAMPLE_CYC (4) cycles. Then 8 trial steps run, from bit 7 down to bit 0. A trial bit is kept when the comparator reports 1 (input at or above the trial code). For an input level v, the result is v.
- R9: On completion, the result register is loaded and the interrupt flag is set. The result register keeps its value until the next completion.
- R10: The interrupt flag is cleared by a one-cycle `irq_clr` strobe. If a completion and a clear fall on the same cycle, the flag stays set.
- R11: The result is loaded SAMPLE_CYC+8 (12) clock edges after the accepting edge, which is well inside the 120-cycle bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Conversion-complete interrupt flag |
| mux_sel | output | 2 | Analog input select |
| sh_strobe | output | 1 | Sample-and-hold strobe |
| trial_code | output | 8 | Code driven to the DAC ladder |
| cmp_in | input | 1 | Comparator result, 1 = input at or above ladder level |

## Verification
The assertions assume the following about the comparator:
- `cmp_in` is a settled function of the present `mux_sel` and `trial_code`;
- it is sampled at the next edge.

They also assume that `irq_clr` and bus writes are held for exactly one clock. The bench models the comparator combinationally from a fixed per-channel level and changes the stimulus only on falling edges, so every rising edge sees stable inputs. The other channels hold the inverted level, so a wrong mux select produces a visibly wrong result.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int DATA_W   = 8;
    localparam int EN_BIT   = 6;
    localparam int CH_LSB   = 2;
    localparam int GO_BIT   = 1;
    localparam int DONE_BIT = 0;
    localparam logic [DATA_W-1:0] CTL_WMASK = 8'h4C;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SAMPLE  = 2'd1,
        PH_RESOLVE = 2'd2
    } phase_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES_W      = 8,
    parameter int CH_W       = 2,
    parameter int SAMPLE_CYC = 4,
    parameter int MAX_CYC    = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o,
    output logic [RES_W-1:0] trial_o,
    output logic             sh_o,
    output logic [CH_W-1:0]  mux_o
);
    localparam int IDX_W = $clog2(RES_W);
    localparam int CNT_W = $clog2(SAMPLE_CYC + 1);
    localparam int LAT_W = $clog2(MAX_CYC + 2);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [RES_W-1:0] acc;
        logic [CH_W-1:0]  ch;
    } seq_t;

    seq_t st_d, st_q;
    logic [RES_W-1:0] bit_mask;
    logic [RES_W-1:0] trial;
    logic             done;

    always_comb begin
        st_d     = st_q;
        done     = 1'b0;
        bit_mask = {{(RES_W-1){1'b0}}, 1'b1} << st_q.idx;
        trial    = st_q.acc | bit_mask;
        case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph  = PH_SAMPLE;
                    st_d.cnt = CNT_W'(SAMPLE_CYC - 1);
                    st_d.ch  = chan_i;
                    st_d.acc = '0;
                end
            end
            PH_SAMPLE: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_RESOLVE;
                    st_d.idx = IDX_W'(RES_W - 1);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_RESOLVE: begin
                if (cmp_i) st_d.acc = trial;
                if (st_q.idx == '0) begin
                    st_d.ph = PH_IDLE;
                    done    = 1'b1;
                end else begin
                    st_d.idx = st_q.idx - 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, idx: '0, acc: '0, ch: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = (st_q.ph != PH_IDLE);
    assign done_o   = done;
    assign result_o = st_d.acc;
    assign trial_o  = (st_q.ph == PH_RESOLVE) ? trial : st_q.acc;
    assign sh_o     = (st_q.ph == PH_SAMPLE);
    assign mux_o    = busy_o ? st_q.ch : chan_i;

    // Cycle counter for the latency bound (R11)
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lat_q <= '0;
        else if (busy_o) lat_q <= lat_q + 1'b1;
        else             lat_q <= '0;
    end

    assert_latency_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (lat_q < LAT_W'(MAX_CYC)))
        else $error("conversion exceeds cycle bound");

    assert_mux_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mux_o))
        else $error("mux select moved during conversion");

    assert_msb_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RESOLVE && st_q.idx != '0) |=>
            (st_q.ph == PH_RESOLVE && st_q.idx == $past(st_q.idx) - 1'b1))
        else $error("trial order broken");

    assert_sample_to_resolve_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sh_o) && busy_o) |-> (st_q.idx == IDX_W'(RES_W - 1)))
        else $error("resolve did not begin at top bit");
endmodule

// File: rtl/sar_regs.sv
module sar_regs
    import sar_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CH_W   = 2,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'hEC,
    parameter logic [ADDR_W-1:0] RES_ADDR = 8'hED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              irq_clr_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] result_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              start_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] ctl;
        logic              go;
        logic [DATA_W-1:0] res;
        logic              irq;
    } reg_t;

    reg_t r_d, r_q;
    logic ctl_wr;
    logic start;

    always_comb begin
        ctl_wr = wr_i && (addr_i == CTL_ADDR);
        start  = ctl_wr && wdata_i[EN_BIT] && wdata_i[GO_BIT] && !busy_i;
        r_d    = r_q;
        if (ctl_wr) r_d.ctl = wdata_i & CTL_WMASK;
        r_d.go = start;
        if (done_i) r_d.res = result_i;
        if (done_i)         r_d.irq = 1'b1;
        else if (irq_clr_i) r_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ctl: '0, go: 1'b0, res: '0, irq: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (addr_i == CTL_ADDR)
            rdata_o = r_q.ctl | {{(DATA_W-2){1'b0}}, r_q.go, !busy_i};
        else if (addr_i == RES_ADDR)
            rdata_o = r_q.res;
        else
            rdata_o = '0;
    end

    assign start_o = start;
    assign chan_o  = ctl_wr ? wdata_i[CH_LSB +: CH_W] : r_q.ctl[CH_LSB +: CH_W];
    assign irq_o   = r_q.irq;

    assert_go_self_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.go |=> !r_q.go)
        else $error("start bit held longer than one cycle");

    assert_disabled_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata_i[EN_BIT]) |=> !r_q.go)
        else $error("start accepted while disabled");

    assert_irq_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> r_q.irq)
        else $error("interrupt not raised at completion");

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(r_q.res))
        else $error("result changed without completion");

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i && !done_i) |=> !r_q.irq)
        else $error("interrupt clear ignored");
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CH_W       = 2,
    parameter int SAMPLE_CYC = 4,
    parameter int MAX_CYC    = 120,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'hEC,
    parameter logic [ADDR_W-1:0] RES_ADDR = 8'hED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_clr,
    output logic              irq_flag,
    output logic [CH_W-1:0]   mux_sel,
    output logic              sh_strobe,
    output logic [DATA_W-1:0] trial_code,
    input  logic              cmp_in
);
    logic              start;
    logic [CH_W-1:0]   chan;
    logic              busy;
    logic              done;
    logic [DATA_W-1:0] result;

    sar_regs #(
        .ADDR_W(ADDR_W), .CH_W(CH_W), .CTL_ADDR(CTL_ADDR), .RES_ADDR(RES_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .irq_clr_i(irq_clr), .busy_i(busy), .done_i(done),
        .result_i(result), .rdata_o(bus_rdata), .start_o(start), .chan_o(chan),
        .irq_o(irq_flag)
    );

    sar_seq #(
        .RES_W(DATA_W), .CH_W(CH_W), .SAMPLE_CYC(SAMPLE_CYC), .MAX_CYC(MAX_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan), .cmp_i(cmp_in),
        .busy_o(busy), .done_o(done), .result_o(result), .trial_o(trial_code),
        .sh_o(sh_strobe), .mux_o(mux_sel)
    );
endmodule

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/1ps
module sim_sar_adc_ctrl;
    localparam logic [7:0] A_CTL = 8'hEC;
    localparam logic [7:0] A_RES = 8'hED;
    localparam int NV = 8;
    // {channel, level}
    localparam logic [9:0] VEC [NV] = '{
        {2'd0, 8'h00}, {2'd1, 8'hFF}, {2'd2, 8'h80}, {2'd3, 8'h7F},
        {2'd0, 8'h55}, {2'd1, 8'hA3}, {2'd2, 8'h01}, {2'd3, 8'hFE}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = A_CTL;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_clr = 1'b0;
    logic       irq_flag;
    logic [1:0] mux_sel;
    logic       sh_strobe;
    logic [7:0] trial_code;
    logic       cmp_in;
    logic [7:0] level [4];

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    assign cmp_in = (level[mux_sel] >= trial_code);

    sar_adc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_clr(irq_clr),
        .irq_flag(irq_flag), .mux_sel(mux_sel), .sh_strobe(sh_strobe),
        .trial_code(trial_code), .cmp_in(cmp_in)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_addr = A_CTL;
    endtask

    // Drive one write through one rising edge; returns just after the next falling edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_CTL;
    endtask

    task automatic set_levels(input logic [1:0] ch, input logic [7:0] v);
        for (int i = 0; i < 4; i++) level[i] = ~v;
        level[ch] = v;
    endtask

    // Full conversion; retrig issues a second start mid-run; clr_at_done strobes irq_clr on the completion edge.
    task automatic convert(input logic [1:0] ch, input logic [7:0] v,
                           input bit retrig, input bit clr_at_done);
        logic [7:0] d;
        int sh_cnt;
        int mux_bad;
        set_levels(ch, v);
        wr(A_CTL, {1'b0, 1'b1, 2'b00, ch, 2'b10});
        sh_cnt = 0; mux_bad = 0;
        rd(A_CTL, d);
        chk("R7 status low while busy", d[0], 1'b0);
        chk("R4 start bit reads 1", d[1], 1'b1);
        chk("R3 mux select", mux_sel, ch);
        if (sh_strobe) sh_cnt++;
        for (int k = 1; k <= 11; k++) begin
            if (retrig && k == 5) begin
                bus_wr = 1'b1; bus_wdata = {1'b0, 1'b1, 2'b00, ~ch, 2'b10};
            end
            @(negedge clk);
            bus_wr = 1'b0;
            if (sh_strobe) sh_cnt++;
            if (mux_sel !== ch) mux_bad++;
            if (k == 1) begin
                rd(A_CTL, d);
                chk("R4 start bit self-clears", d[1], 1'b0);
            end
            if (k == 11) begin
                rd(A_CTL, d);
                chk("R11 still busy before edge 12", d[0], 1'b0);
                if (clr_at_done) irq_clr = 1'b1;
            end
        end
        chk("R8 sample strobe length", sh_cnt, 4);
        chk("R3 mux held during conversion", mux_bad, 0);
        @(negedge clk);
        irq_clr = 1'b0;
        rd(A_CTL, d);
        chk("R7 status set at completion", d[0], 1'b1);
        rd(A_RES, d);
        chk(retrig ? "R6 original result kept" : "R8 result equals level", d, v);
        chk("R9 interrupt raised", irq_flag, 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 4; i++) level[i] = 8'h00;
        #12 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        rd(A_CTL, d); chk("R1 control reset", d, 8'h01);
        rd(A_RES, d); chk("R1 result reset", d, 8'h00);
        chk("R1 irq reset", irq_flag, 1'b0);
        chk("R1 strobe reset", sh_strobe, 1'b0);

        // R2: layout and unused bits (no start, bit 1 clear)
        wr(A_CTL, 8'hFD);
        rd(A_CTL, d); chk("R2 layout readback", d, 8'h4D);
        chk("R4 writing start 0 does nothing", sh_strobe, 1'b0);

        // R5: start with enable clear is ignored
        wr(A_CTL, 8'h02);
        rd(A_CTL, d); chk("R5 disabled start ignored", d, 8'h01);
        chk("R5 no sampling", sh_strobe, 1'b0);

        // Vector table walk
        for (int n = 0; n < NV; n++) begin
            convert(VEC[n][9:8], VEC[n][7:0], 1'b0, 1'b0);
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            chk("R10 irq cleared", irq_flag, 1'b0);
        end

        // R9: result holds across unrelated writes
        wr(A_CTL, 8'h4C);
        rd(A_RES, d); chk("R9 result held", d, VEC[NV-1][7:0]);

        // R6: re-start while busy ignored
        convert(2'd1, 8'h3C, 1'b1, 1'b0);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

        // R10: clear on completion edge, set wins
        convert(2'd2, 8'hC9, 1'b0, 1'b1);
        chk("R10 set wins over clear", irq_flag, 1'b1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk("R10 later clear", irq_flag, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule